// File: doc/BRIEF.md
# Modem GPIO Register Bank

This block is the register bank that governs a five-pin general-purpose I/O group on a serial audio-link codec. A host reaches it through a plain indexed port. A strobe, an index and 16 data bits write a register. A read strobe returns one word on the following clock. Three words are implemented. The identity word reports a two-bit codec identity strapped at power-up. The status/control word carries a powerdown control and a read-only ready flag. The pin-direction word holds one input/output bit per pin.

Any write to the identity word, whatever its data, starts a modem register reset. It returns the powerdown control and the direction word to their defaults and leaves the strapped identity alone. The powerdown control gates every pin output enable. The ready flag follows the inverse of powerdown one cycle late and, while the link is active, qualifies the slot-12 valid indication. Four serial-port enable inputs can take pins away from the direction register. Pins 1:0 share the first enable, and pins 2, 3 and 4 take one enable each. A pin taken this way reads 0 and ignores writes.

A three-state sequencer orders the work. ST_LATCH is the single cycle after reset in which the strap is captured, and it always moves to ST_RUN. ST_RUN accepts writes. A write to the identity index moves it to ST_MRST. ST_MRST applies the modem reset for one cycle, ignores writes, and always returns to ST_RUN.

Top module: `modem_gpio_regs`

## Requirements
- R1: After reset, index 3Eh reads 0100h and index 4Ch reads 001Fh. gpio_ready, slot12_valid and every gpio_oe bit are 0.
- R2: Index 3Ch reads the strap value captured on the first clock after reset in bits 15:14, with 0 in bits 13:0. Later changes on id_strap, and modem resets, leave it unchanged.
- R3: rd_valid pulses and rd_data updates on the clock after a cycle with rd_en high. An index other than 3Ch, 3Eh or 4Ch reads 0000h.
- R4: A write to an index other than 3Ch, 3Eh or 4Ch changes no register, even when its low bits match an implemented index.
- R5: A write of any data to index 3Ch causes, on the following clock, powerdown = 1 and all direction bits = 1 (3Eh reads 0100h once ready settles, 4Ch reads 001Fh). All gpio_oe bits read 0.
- R6: Bit 8 of 3Eh is the writable powerdown control. Bit 0 is the read-only ready flag, equal to the inverse of powerdown one clock after powerdown changes. Writes to all other bits of 3Eh are ignored.
- R7: While powerdown is 1, every gpio_oe bit is 0, from the clock that sets it.
- R8: gpio_oe[i] is 1 exactly when powerdown is 0, direction bit i is 0, and pin i's serial-port enable is 0.
- R9: Bits 4:0 of 4Ch are the direction bits (1 = input, 0 = output). Bits 15:5 read 0 whatever is written.
- R10: sp_en[0] claims pins 1:0, sp_en[1] pin 2, sp_en[2] pin 3 and sp_en[3] pin 4. A claimed pin's direction bit reads 0 and keeps its stored value through writes. When the enable drops, the stored value reads back.
- R11: slot12_valid is 1 exactly when gpio_ready is 1 and link_active is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| id_strap | input | 2 | Codec identity strap, captured once after reset |
| link_active | input | 1 | Serial link is running |
| sp_en | input | 4 | Serial-port enables that claim GPIO pins |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| reg_idx | input | 7 | Register index |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one clock after rd_en |
| gpio_oe | output | 5 | Per-pin output enable (0 = tri-state) |
| gpio_ready | output | 1 | GPIO subsystem ready flag |
| slot12_valid | output | 1 | Slot-12 valid indication |

## Verification
A wrong powerdown or direction state shows up at gpio_oe in the same cycle the register changes. The ready flag and slot12_valid lag it by exactly one clock, so a lost or doubled lag stage is visible one cycle after a powerdown write. A sequencer that sits in ST_MRST too long, or skips it, shows up as dropped writes or as defaults that never return. The bench catches this with a read one cycle after the reset edge. The masking by sp_en is checked on both sides of a claim, so a write that leaks into a claimed pin appears as soon as the claim is released.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;
    localparam int DW      = 16;
    localparam int IW      = 7;
    localparam int NPIN    = 5;
    localparam int NSP     = NPIN - 1;
    localparam int IDW     = 2;
    localparam int IDX_ID  = 'h3C;
    localparam int IDX_ST  = 'h3E;
    localparam int IDX_GPC = 'h4C;
    localparam int PD_BIT  = 8;
    localparam int RDY_BIT = 0;

    typedef enum logic [1:0] {
        ST_LATCH = 2'd0,
        ST_RUN   = 2'd1,
        ST_MRST  = 2'd2
    } seq_t;

    // pins 0 and 1 share enable 0, every later pin has its own
    function automatic int sp_sel(input int pin);
        return (pin < 2) ? 0 : pin - 1;
    endfunction
endpackage

// File: rtl/mgpio_seq.sv
module mgpio_seq
    import mgpio_pkg::*;
#(
    parameter int P_IW  = IW,
    parameter int P_IDW = IDW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [P_IW-1:0]  reg_idx,
    input  logic [P_IDW-1:0] id_strap,
    output logic             wr_ok,
    output logic             mrst,
    output logic [P_IDW-1:0] id_q
);
    seq_t state_q, state_d;
    logic id_wr;

    assign id_wr = wr_en && (reg_idx == P_IW'(IDX_ID));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LATCH;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LATCH: state_d = ST_RUN;
            ST_RUN:   if (id_wr) state_d = ST_MRST;
            ST_MRST:  state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_comb begin
        wr_ok = (state_q == ST_RUN);
        mrst  = (state_q == ST_MRST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  id_q <= '0;
        else if (state_q == ST_LATCH) id_q <= id_strap;
    end

    AST_MRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_MRST |=> state_q == ST_RUN); // R5
    AST_ID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != ST_LATCH |=> $stable(id_q)); // R2
endmodule

// File: rtl/mgpio_ctl.sv
module mgpio_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic mrst,
    input  logic st_wr,
    input  logic pd_wd,
    output logic pd_q,
    output logic rdy_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pd_q <= 1'b1;
        else if (mrst)  pd_q <= 1'b1;
        else if (st_wr) pd_q <= pd_wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdy_q <= 1'b0;
        else        rdy_q <= ~pd_q;
    end

    AST_RDY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        pd_q |=> !rdy_q); // R6
    AST_RDY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_q |=> rdy_q); // R6
    AST_MRST_PD: assert property (@(posedge clk) disable iff (!rst_n)
        mrst |=> pd_q); // R5
endmodule

// File: rtl/mgpio_cfg.sv
module mgpio_cfg
    import mgpio_pkg::*;
#(
    parameter int P_NPIN = NPIN,
    localparam int L_NSP = P_NPIN - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrst,
    input  logic              cfg_wr,
    input  logic [P_NPIN-1:0] wd,
    input  logic [L_NSP-1:0]  sp_en,
    input  logic              pd,
    output logic [P_NPIN-1:0] gc_q,
    output logic [P_NPIN-1:0] gc_eff,
    output logic [P_NPIN-1:0] oe
);
    for (genvar p = 0; p < P_NPIN; p++) begin : g_pin
        localparam int SEL = sp_sel(p);
        logic ovr;
        assign ovr = sp_en[SEL];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               gc_q[p] <= 1'b1;
            else if (mrst)            gc_q[p] <= 1'b1;
            else if (cfg_wr && !ovr)  gc_q[p] <= wd[p];
        end

        assign gc_eff[p] = gc_q[p] & ~ovr;
        assign oe[p]     = ~pd & ~gc_q[p] & ~ovr;
    end

    AST_MRST_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        mrst |=> gc_q == '1); // R5
endmodule

// File: rtl/modem_gpio_regs.sv
module modem_gpio_regs
    import mgpio_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IDW-1:0]  id_strap,
    input  logic            link_active,
    input  logic [NSP-1:0]  sp_en,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [IW-1:0]   reg_idx,
    input  logic [DW-1:0]   wr_data,
    output logic [DW-1:0]   rd_data,
    output logic            rd_valid,
    output logic [NPIN-1:0] gpio_oe,
    output logic            gpio_ready,
    output logic            slot12_valid
);
    logic           wr_ok, mrst;
    logic [IDW-1:0] id_q;
    logic           pd_q, rdy_q;
    logic [NPIN-1:0] gc_q, gc_eff;
    logic           hit_id, hit_st, hit_gpc, idx_hit;
    logic [DW-1:0]  rd_word;

    assign hit_id  = (reg_idx == IW'(IDX_ID));
    assign hit_st  = (reg_idx == IW'(IDX_ST));
    assign hit_gpc = (reg_idx == IW'(IDX_GPC));
    assign idx_hit = hit_id | hit_st | hit_gpc;

    mgpio_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .reg_idx  (reg_idx),
        .id_strap (id_strap),
        .wr_ok    (wr_ok),
        .mrst     (mrst),
        .id_q     (id_q)
    );

    mgpio_ctl u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .mrst  (mrst),
        .st_wr (wr_en && wr_ok && hit_st),
        .pd_wd (wr_data[PD_BIT]),
        .pd_q  (pd_q),
        .rdy_q (rdy_q)
    );

    mgpio_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .mrst   (mrst),
        .cfg_wr (wr_en && wr_ok && hit_gpc),
        .wd     (wr_data[NPIN-1:0]),
        .sp_en  (sp_en),
        .pd     (pd_q),
        .gc_q   (gc_q),
        .gc_eff (gc_eff),
        .oe     (gpio_oe)
    );

    always_comb begin
        rd_word = '0;
        if (hit_id) begin
            rd_word[DW-1 -: IDW] = id_q;
        end else if (hit_st) begin
            rd_word[PD_BIT]  = pd_q;
            rd_word[RDY_BIT] = rdy_q;
        end else if (hit_gpc) begin
            rd_word[NPIN-1:0] = gc_eff;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_word;
        end
    end

    assign gpio_ready   = rdy_q;
    assign slot12_valid = rdy_q & link_active;

    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R3
    AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid); // R3
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !idx_hit |=> rd_data == '0); // R3
    AST_PD_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pd_q |-> gpio_oe == '0); // R7
    AST_SLOT_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        slot12_valid |-> gpio_ready); // R11
    AST_GC_UNUSED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && hit_gpc |=> rd_data[DW-1:NPIN] == '0); // R9
endmodule

// File: tb/sim_modem_gpio_regs.sv
module sim_modem_gpio_regs;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  id_strap = 2'b10;
    logic        link_active = 1'b1;
    logic [3:0]  sp_en = 4'b0000;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [6:0]  reg_idx = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic [4:0]  gpio_oe;
    logic        gpio_ready;
    logic        slot12_valid;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    modem_gpio_regs u0 (
        .clk(clk), .rst_n(rst_n), .id_strap(id_strap), .link_active(link_active),
        .sp_en(sp_en), .wr_en(wr_en), .rd_en(rd_en), .reg_idx(reg_idx),
        .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
        .gpio_oe(gpio_oe), .gpio_ready(gpio_ready), .slot12_valid(slot12_valid)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] idx, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] idx, input logic [15:0] e, input string tag);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(tag);
        rd_en = 1'b1; reg_idx = idx;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R3: actual rd_valid=1 expected no pending read");
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", t, rd_data, e);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG_LIMIT && !done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        chk({15'd0, gpio_ready}, 16'h0000, "R1 ready");
        chk({11'd0, gpio_oe}, 16'h0000, "R1 oe");
        chk({15'd0, slot12_valid}, 16'h0000, "R1 slot12");
        rd(7'h3E, 16'h0100, "R1 status");
        rd(7'h4C, 16'h001F, "R1 dir");
        // R2 identity latched, strap changes ignored
        rd(7'h3C, 16'h8000, "R2 id");
        id_strap = 2'b01;
        idle(2);
        rd(7'h3C, 16'h8000, "R2 id after strap change");
        // R3 unmapped reads
        rd(7'h10, 16'h0000, "R3 unmapped");
        rd(7'h4E, 16'h0000, "R3 unmapped near");
        // R9 direction write with upper bits set, R7 powerdown still on
        wr(7'h4C, 16'hFFE0);
        rd(7'h4C, 16'h0000, "R9 upper bits zero");
        chk({11'd0, gpio_oe}, 16'h0000, "R7 oe while powered down");
        // R6 clear powerdown, ready lags one clock
        wr(7'h3E, 16'hFEFF);
        chk({15'd0, gpio_ready}, 16'h0000, "R6 ready lag");
        idle(1);
        chk({15'd0, gpio_ready}, 16'h0001, "R6 ready set");
        rd(7'h3E, 16'h0001, "R6 status readback");
        // R11 slot12 qualification
        chk({15'd0, slot12_valid}, 16'h0001, "R11 slot12 link on");
        link_active = 1'b0;
        idle(1);
        chk({15'd0, slot12_valid}, 16'h0000, "R11 slot12 link off");
        link_active = 1'b1;
        // R8 output enables
        chk({11'd0, gpio_oe}, 16'h001F, "R8 all outputs");
        wr(7'h4C, 16'h0005);
        chk({11'd0, gpio_oe}, 16'h001A, "R8 mixed");
        rd(7'h4C, 16'h0005, "R9 dir readback");
        // R10 claim pins 1:0
        sp_en = 4'b0001;
        idle(1);
        chk({11'd0, gpio_oe}, 16'h0018, "R10 oe claim low");
        rd(7'h4C, 16'h0004, "R10 claimed read zero");
        wr(7'h4C, 16'h001F);
        rd(7'h4C, 16'h001C, "R10 claimed write ignored");
        chk({11'd0, gpio_oe}, 16'h0000, "R10 oe after write");
        sp_en = 4'b0000;
        idle(1);
        rd(7'h4C, 16'h001D, "R10 release low");
        chk({11'd0, gpio_oe}, 16'h0002, "R8 after release");
        // R10 claim pins 4:2
        sp_en = 4'b1110;
        wr(7'h4C, 16'h0000);
        rd(7'h4C, 16'h0000, "R10 claimed high read zero");
        chk({11'd0, gpio_oe}, 16'h0003, "R10 oe claim high");
        sp_en = 4'b0000;
        idle(1);
        rd(7'h4C, 16'h001C, "R10 release high");
        // R4 unmapped writes
        wr(7'h50, 16'h0000);
        wr(7'h0C, 16'h0000);
        wr(7'h7E, 16'h0100);
        rd(7'h3E, 16'h0001, "R4 status unchanged");
        rd(7'h4C, 16'h001C, "R4 dir unchanged");
        // R7 powerdown cuts outputs at once
        wr(7'h3E, 16'h0100);
        chk({11'd0, gpio_oe}, 16'h0000, "R7 oe off");
        chk({15'd0, gpio_ready}, 16'h0001, "R6 ready lag on powerdown");
        idle(1);
        chk({15'd0, gpio_ready}, 16'h0000, "R6 ready cleared");
        chk({15'd0, slot12_valid}, 16'h0000, "R11 slot12 off");
        wr(7'h3E, 16'h0000);
        idle(1);
        chk({11'd0, gpio_oe}, 16'h0003, "R8 re-enabled");
        // R5 modem reset via identity write
        wr(7'h3C, 16'h1234);
        idle(1);
        chk({11'd0, gpio_oe}, 16'h0000, "R5 oe after reset");
        rd(7'h3E, 16'h0100, "R5 status default");
        rd(7'h4C, 16'h001F, "R5 dir default");
        rd(7'h3C, 16'h8000, "R5 R2 id kept");
        idle(3);
        chk(16'(exp_q.size()), 16'h0000, "R3 all reads answered");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule